// File: doc/BRIEF.md
# Synchronous Byte-Wide Configuration Loader

This block takes in a configuration bitstream one byte at a time. The byte arrives on an 8-bit parallel bus and is timed by a single externally supplied clock, the only clock in the design. An initialization-ready input opens each loading session. Once it is high, the block captures the bus at fixed points in the clock count. The first capture comes on the second rising edge that sees the input high. After that, one byte is captured every eighth rising edge.

Each accepted byte does three things:
- it raises a one-clock acknowledge pulse;
- it is offered to internal consumers on a captured-byte bus with a matching valid strobe;
- it is forwarded, least significant bit first, on a serial pass-through output so that a further device can be chained behind this one.

The serial output changes on the falling clock edge, half a period after the parallel load. The stream therefore lags the input. The last byte only leaves the block completely if the source keeps toggling the clock after it.

At board level the clock runs at no more than 8 MHz. The init-ready input should be high well ahead (microseconds) of the first capturing edge. The data bus must be stable a short setup time before each capturing edge.

Top module: `cfg_sync_loader`

## Requirements
- R1: With `init_ok` low at the previous edge, call the first rising edge that samples `init_ok` high edge 1. The bus `din` is captured at edge 2, provided `init_ok` is still high there. No capture happens at edge 1.
- R2: After the first capture, `din` is captured again at every eighth rising edge (edges 10, 18, 26, ...), as long as `init_ok` stays high. No capture happens at any edge in between.
- R3: `ack` is high for exactly the one clock period that follows each capturing edge, and is low otherwise.
- R4: `cap_valid` is high in the same cycle as `ack`. During that cycle `cap_byte` holds the value `din` had at the capturing edge.
- R5: On the falling edge after a capturing edge, `sdo` shows bit 0 of the captured byte. At the falling edge after each later rising edge, `sdo` shows the next higher bit, so bit 7 appears after the seventh following rising edge.
- R6: A capture replaces the serial contents exactly when the previous byte's bit 7 has been emitted. Consecutive bytes therefore form one unbroken stream of 8 bits per byte.
- R7: After the final byte, shifting continues on every clock while `init_ok` is high. When its 8 bits are done, `sdo` is 0 until the next capture.
- R8: A rising edge that samples `init_ok` low restarts the capture count (R1 applies again afterwards). After that edge, `ack` and `cap_valid` are low, and `sdo` is low from the following falling edge.
- R9: A rising edge with `rst` high has the same effect as R8. This reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Externally supplied configuration clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| init_ok | input | 1 | Initialization-ready; high enables capture counting |
| din | input | 8 | Parallel configuration byte |
| ack | output | 1 | One-cycle acknowledge after each capture |
| cap_valid | output | 1 | Captured-byte strobe for internal consumers |
| cap_byte | output | 8 | Most recently captured byte |
| sdo | output | 1 | Serial pass-through, LSB first, changes on falling edge |

## Verification
The reference model counts rising edges since `init_ok` was first sampled high. From that count it predicts a capture at edge 2 and at every eighth edge after it. `ack`, `cap_valid` and `cap_byte` are due one register later, so they are compared in the cycle that follows the capturing edge. `sdo` is due half a period after each rising edge, so the bench samples three quarters of a period after the edge, once the falling-edge update has settled. At that point it compares `sdo` with the next bit taken from a model queue that a capture refills. Stimulus changes `din` on every clock to show that only the predicted edges take data. The run includes flush clocks, an `init_ok` drop in the middle of a byte, and a reset in the middle of a stream.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] cfg_byte_t;

    // one accepted byte as seen by internal consumers
    typedef struct packed {
        logic      valid;
        cfg_byte_t data;
    } cap_word_t;

    // LSB-first serialiser step: drop the emitted bit, fill with zero
    function automatic cfg_byte_t shift_lsb_out(input cfg_byte_t v);
        return v >> 1;
    endfunction

endpackage

// File: rtl/cfg_phase_ctr.sv
// Edge counter that decides which rising edges capture the bus.
module cfg_phase_ctr #(
    parameter int unsigned PERIOD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic init_ok,
    output logic cap_stb
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
    // preset so the second edge with init_ok high lands on LAST
    localparam logic [CW-1:0] PRESET = CW'(PERIOD - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !init_ok) begin
            cnt <= PRESET;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cap_stb = init_ok && !rst && (cnt == LAST);

    // first edge seeing init high never captures; the next one does
    p_first_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(init_ok) |-> !cap_stb);
    p_second_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(init_ok) |=> (cap_stb || !init_ok));
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !init_ok |=> !cap_stb);
    p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> !cap_stb);

endmodule

// File: rtl/cfg_byte_capture.sv
// Parallel capture register with acknowledge and consumer strobe.
module cfg_byte_capture
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_ok,
    input  logic      cap_stb,
    input  cfg_byte_t din,
    output cap_word_t cap,
    output logic      ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
            ack <= 1'b0;
        end else begin
            ack       <= cap_stb;
            cap.valid <= cap_stb;
            if (cap_stb) begin
                cap.data <= din;
            end
        end
    end

    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_ack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !init_ok |=> !ack);
    p_ack_follows_r3: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> ack);

endmodule

// File: rtl/cfg_serial_fwd.sv
// LSB-first serial forwarder; output register moves on the falling edge.
module cfg_serial_fwd
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_ok,
    input  logic      load,
    input  cfg_byte_t din,
    output cfg_byte_t sreg,
    output logic      sdo
);
    always_ff @(posedge clk) begin
        if (rst || !init_ok) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else begin
            sreg <= shift_lsb_out(sreg);
        end
    end

    // half-period offset: present the current LSB on the falling edge
    always_ff @(negedge clk) begin
        sdo <= sreg[0];
    end

    p_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (init_ok && !load && $past(init_ok)) |=> (sreg[BYTE_W-1] == 1'b0));

endmodule

// File: rtl/cfg_sync_loader.sv
module cfg_sync_loader
    import cfg_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init_ok,
    input  logic [7:0] din,
    output logic       ack,
    output logic       cap_valid,
    output logic [7:0] cap_byte,
    output logic       sdo
);
    logic      cap_stb;
    cap_word_t cap;
    cfg_byte_t sreg;

    cfg_phase_ctr #(.PERIOD(BYTE_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .init_ok (init_ok),
        .cap_stb (cap_stb)
    );

    cfg_byte_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .init_ok (init_ok),
        .cap_stb (cap_stb),
        .din     (din),
        .cap     (cap),
        .ack     (ack)
    );

    cfg_serial_fwd u_ser (
        .clk     (clk),
        .rst     (rst),
        .init_ok (init_ok),
        .load    (cap_stb),
        .din     (din),
        .sreg    (sreg),
        .sdo     (sdo)
    );

    assign cap_valid = cap.valid;
    assign cap_byte  = cap.data;

    // serial register and consumer bus are loaded by separate logic
    p_same_byte_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && init_ok && $past(init_ok)) |-> (sreg == cap.data));
    p_strobe_pair_r4: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> ack);

endmodule

// File: tb/sim_cfg_sync_loader.sv
module sim_cfg_sync_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_ok = 1'b0;
    logic [7:0] din = 8'h00;
    logic       ack, cap_valid, sdo;
    logic [7:0] cap_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag = "R9";

    always #2 clk = ~clk;

    cfg_sync_loader u0 (
        .clk(clk), .rst(rst), .init_ok(init_ok), .din(din),
        .ack(ack), .cap_valid(cap_valid), .cap_byte(cap_byte), .sdo(sdo)
    );

    // behavioural reference model
    int   edges = 0;
    bit   bitq[$];
    bit   exp_ack = 1'b0;
    logic [7:0] exp_byte = 8'h00;
    bit   exp_sdo = 1'b0;

    task automatic check(input string req, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, expv, $time);
        end
    endtask

    always begin
        @(posedge clk);
        if (!done) begin
            bit cap_now;
            cap_now = 1'b0;
            if (rst || !init_ok) begin
                edges = 0;
                bitq.delete();
            end else begin
                edges++;
                // R1 first capture at edge 2, R2 every eighth edge after
                cap_now = (edges >= 2) && (((edges - 2) % 8) == 0);
                if (cap_now) begin
                    bitq.delete();      // R6 previous byte fully emitted here
                    for (int i = 0; i < 8; i++) bitq.push_back(din[i]);
                    exp_byte = din;
                end
            end
            exp_ack = cap_now;
            exp_sdo = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;  // R7 zeros
            #3;
            check((edges == 2) ? "R1 ack" : "R3 ack", ack, exp_ack);
            check("R4 valid", cap_valid, exp_ack);
            if (exp_ack) begin
                total++;
                if (cap_byte !== exp_byte) begin
                    bad++;
                    $display("FAIL R4 byte actual=%h expected=%h", cap_byte, exp_byte);
                end
            end
            check({tag, " R5 sdo"}, sdo, exp_sdo);
        end
    end

    int seed = 32'h1234_5678;
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            seed = seed * 1103515245 + 12345;
            din = seed[23:16];
        end
    endtask

    initial begin
        tag = "R9";  run(3);             // reset state
        @(posedge clk); #1 rst = 1'b0;
        run(4);
        tag = "R2"; init_ok = 1'b1;      // R1/R2/R6 streaming
        run(60);
        tag = "R8"; init_ok = 1'b0;      // drop mid-byte
        run(3);
        tag = "R1"; init_ok = 1'b1;      // restart timing
        run(13);
        tag = "R7";                      // flush clocks: stream keeps draining
        run(30);
        tag = "R9"; rst = 1'b1;          // reset mid-stream
        run(2);
        rst = 1'b0; tag = "R6";
        run(40);
        @(posedge clk); #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule